// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block holds the operating state of a serial peripheral core and changes it on register writes from firmware. The core can be in one of three states: reset, run or pause. Firmware requests a state by writing a two-bit code into the state register. It reads back the current code together with a ready flag. The flag drops for a fixed settle time after each accepted change. Firmware is expected to wait for the flag to be high before it issues a request, and to wait for it again afterwards.

Leaving pause for reset is guarded. A direct write of the reset code while paused is refused. The exit needs the clear code written twice, with no other register write between the two writes. A separate software-reset register forces the reset state at any time.

The block drives two levels into the data path. One is a run enable, high only in run. The other is a data-path reset, held for as long as the state is reset.

Top module: `run_state_ctrl`

## Requirements
- R1: The status read-back `st_rdata[1:0]` holds the state code: 0 means reset, 1 means run and 3 means pause. Code 2 is never a state; it is the clear command. `st_rdata[2]` is the ready flag. After `rst_n` the read-back is 3'b100, `err_o` is 0, `run_en` is 0 and `dp_rst` is 1.
- R2: While ready is high, a single state write of code 1 or 3 moves to that state from any state, and a write of code 0 from reset or run moves to reset. The new code is visible after the clock edge that samples the write.
- R3: After every accepted change, ready is low for exactly SETTLE cycles (default 4) and then rises. A change is accepted when it is a single write, the second clear write, or a forcing software reset. Without a new accepted change, ready stays high.
- R4: A state write that arrives while ready is low changes nothing, does not restart the settle time, and sets `err_o`. `err_o` stays set until `rst_n`.
- R5: In pause, a first write of code 2 arms the exit: the state stays pause and ready stays high. A second write of code 2 with no register write in between moves to reset and starts the settle time.
- R6: When the exit is armed, any register write other than code 2 to the state register disarms it and the state stays pause. This covers any other state write, any software-reset write and any other register write (`oth_wr`). A later single write of code 2 only re-arms the exit. A state write of code 1 that disarms also moves to run.
- R7: A write of code 0 in pause, and a write of code 2 in reset or run, change nothing and leave ready high.
- R8: A software-reset write with `srst_wdata`=1 forces the reset state from any state, even while ready is low, and starts the settle time. With `srst_wdata`=0 the state does not change.
- R9: `run_en` is high exactly in the run state and `dp_rst` is high exactly in the reset state. Both are low in pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr | input | 1 | Write strobe for the state register |
| st_wdata | input | 2 | Requested state code |
| srst_wr | input | 1 | Write strobe for the software-reset register |
| srst_wdata | input | 1 | Software-reset data bit (1 forces reset) |
| oth_wr | input | 1 | Strobe marking a write to any other register of the core |
| st_rdata | output | 3 | Status read-back: {ready, state code} |
| err_o | output | 1 | Sticky flag for writes made while not ready |
| run_en | output | 1 | Data-path run enable |
| dp_rst | output | 1 | Data-path reset level |

## Verification
A table of writes walks the state through every legal single-write transition. It also covers the refused pause-to-reset write, clear codes in states where they mean nothing, and clear pairs broken by each kind of intervening write. Each step compares the state and the ready flag, then counts the ready-low cycles exactly. This separates a refused write from a settled one, and an armed exit from a completed one. Directed tests then write during the settle window, to tell an ignored write from one that restarts the timer. They also fire a software reset during a settle, which must override it, and check that the error flag persists.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2,
    ST_PAUSE = 2'd3
  } st_code_e;

  // A code names a real state unless it is the clear command.
  function automatic logic is_target(input logic [1:0] code);
    return code != ST_CLEAR;
  endfunction

  // A single write is honoured for every target except reset out of pause.
  function automatic logic single_ok(input logic [1:0] cur, input logic [1:0] req);
    return is_target(req) && !((cur == ST_PAUSE) && (req == ST_RESET));
  endfunction

endpackage

// File: rtl/rsc_settle_timer.sv
module rsc_settle_timer #(
  parameter int SETTLE = 4,
  localparam int CW = $clog2(SETTLE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic ready_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CW'(SETTLE);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = (cnt_q == '0);

  // R3: an accepted change always opens a settle window
  p_settle_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !ready_o);

  // R3: ready never falls without a load
  p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !load_i) |=> ready_o);

endmodule

// File: rtl/rsc_clear_seq.sv
module rsc_clear_seq
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr_i,
  input  logic [1:0] st_data_i,
  input  logic       other_wr_i,
  input  logic       ready_i,
  input  logic       in_pause_i,
  output logic       armed_o,
  output logic       clr_done_o
);

  logic clr_hit;
  logic any_wr;

  assign clr_hit    = st_wr_i && ready_i && in_pause_i && (st_data_i == ST_CLEAR);
  assign any_wr     = st_wr_i || other_wr_i;
  assign clr_done_o = clr_hit && armed_o && !other_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
    end else if (!in_pause_i) begin
      armed_o <= 1'b0;
    end else if (clr_hit && !armed_o && !other_wr_i) begin
      armed_o <= 1'b1;
    end else if (any_wr) begin
      armed_o <= 1'b0;
    end
  end

  // R5: the exit can only be armed while paused
  p_armed_in_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |-> in_pause_i);

  // R6: any write that is not a clear code disarms
  p_abort_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr_i || (st_wr_i && st_data_i != ST_CLEAR)) |=> !armed_o);

endmodule

// File: rtl/rsc_state_core.sv
module rsc_state_core
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr_i,
  input  logic [1:0] st_data_i,
  input  logic       srst_go_i,
  input  logic       clr_done_i,
  input  logic       ready_i,
  output logic [1:0] state_o,
  output logic       accept_o,
  output logic       err_o
);

  logic busy_wr;
  logic single_go;

  assign busy_wr   = st_wr_i && !ready_i;
  assign single_go = st_wr_i && ready_i && single_ok(state_o, st_data_i);
  assign accept_o  = srst_go_i || clr_done_i || single_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= ST_RESET;
    end else if (srst_go_i || clr_done_i) begin
      state_o <= ST_RESET;
    end else if (single_go) begin
      state_o <= st_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o <= 1'b0;
    end else if (busy_wr) begin
      err_o <= 1'b1;
    end
  end

  // R4: a write made while not ready leaves the state alone
  p_busy_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_wr && !srst_go_i) |=> (state_o == $past(state_o)));

  // R4: the error flag is sticky
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R8: a forcing software reset always lands in reset
  p_srst_forces_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_go_i |=> (state_o == ST_RESET));

  // R7: pause never reaches reset without the clear pair or a software reset
  p_pause_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_PAUSE && !srst_go_i && !clr_done_i) |=> (state_o != ST_RESET));

  // R1: the clear code is never held as a state
  p_no_clear_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != ST_CLEAR);

endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl
  import rsc_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr,
  input  logic [1:0] st_wdata,
  input  logic       srst_wr,
  input  logic       srst_wdata,
  input  logic       oth_wr,
  output logic [2:0] st_rdata,
  output logic       err_o,
  output logic       run_en,
  output logic       dp_rst
);

  logic       ready;
  logic       accept;
  logic       srst_go;
  logic       armed;
  logic       clr_done;
  logic [1:0] state;

  assign srst_go = srst_wr && srst_wdata;

  rsc_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .ready_o (ready)
  );

  rsc_clear_seq u_clr (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_wr_i    (st_wr),
    .st_data_i  (st_wdata),
    .other_wr_i (srst_wr || oth_wr),
    .ready_i    (ready),
    .in_pause_i (state == ST_PAUSE),
    .armed_o    (armed),
    .clr_done_o (clr_done)
  );

  rsc_state_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_wr_i    (st_wr),
    .st_data_i  (st_wdata),
    .srst_go_i  (srst_go),
    .clr_done_i (clr_done),
    .ready_i    (ready),
    .state_o    (state),
    .accept_o   (accept),
    .err_o      (err_o)
  );

  assign st_rdata = {ready, state};
  assign run_en   = (state == ST_RUN);
  assign dp_rst   = (state == ST_RESET);

  // R9: the data-path controls never overlap
  p_ctrl_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_en, dp_rst}));

  // R5: finishing the clear pair lands in reset with a settle window
  p_clear_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> (st_rdata == {1'b0, ST_RESET}));

  // R9: pause drives neither control
  p_pause_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rdata[1:0] == ST_PAUSE) |-> (!run_en && !dp_rst));

endmodule

// File: tb/run_state_ctrl_tb_top.sv
module run_state_ctrl_tb_top;

  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st_wr = 1'b0;
  logic [1:0] st_wdata = 2'd0;
  logic       srst_wr = 1'b0;
  logic       srst_wdata = 1'b0;
  logic       oth_wr = 1'b0;
  logic [2:0] st_rdata;
  logic       err_o;
  logic       run_en;
  logic       dp_rst;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  run_state_ctrl #(.SETTLE(SETTLE)) dut_i (
    .clk, .rst_n, .st_wr, .st_wdata, .srst_wr, .srst_wdata, .oth_wr,
    .st_rdata, .err_o, .run_en, .dp_rst
  );

  // vector: {op[1:0], data[1:0], exp_state[1:0], exp_ready}
  // op 0 = state write, 1 = software-reset write, 2 = other register write
  localparam int NV = 21;
  localparam logic [6:0] VEC [0:NV-1] = '{
    {2'd0, 2'd1, 2'd1, 1'b0},  // R2 reset->run
    {2'd0, 2'd3, 2'd3, 1'b0},  // R2 run->pause
    {2'd0, 2'd1, 2'd1, 1'b0},  // R2 pause->run
    {2'd0, 2'd3, 2'd3, 1'b0},  // R2 run->pause
    {2'd0, 2'd2, 2'd3, 1'b1},  // R5 arm
    {2'd0, 2'd2, 2'd0, 1'b0},  // R5 complete
    {2'd0, 2'd1, 2'd1, 1'b0},  // R2
    {2'd0, 2'd2, 2'd1, 1'b1},  // R7 clear in run
    {2'd0, 2'd3, 2'd3, 1'b0},  // R2
    {2'd0, 2'd0, 2'd3, 1'b1},  // R7 reset code refused in pause
    {2'd0, 2'd2, 2'd3, 1'b1},  // R5 arm
    {2'd2, 2'd0, 2'd3, 1'b1},  // R6 other write aborts
    {2'd0, 2'd2, 2'd3, 1'b1},  // R6 single clear only re-arms
    {2'd1, 2'd0, 2'd3, 1'b1},  // R6/R8 srst data 0 aborts, no change
    {2'd0, 2'd2, 2'd3, 1'b1},  // R6 re-arm only
    {2'd0, 2'd2, 2'd0, 1'b0},  // R5 complete
    {2'd0, 2'd0, 2'd0, 1'b0},  // R2 same-state write accepted
    {2'd0, 2'd1, 2'd1, 1'b0},  // R2
    {2'd0, 2'd0, 2'd0, 1'b0},  // R2 run->reset
    {2'd0, 2'd1, 2'd1, 1'b0},  // R2
    {2'd1, 2'd1, 2'd0, 1'b0}   // R8 srst from run
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] op, input logic [1:0] data);
    @(negedge clk);
    st_wr      = (op == 2'd0);
    srst_wr    = (op == 2'd1);
    oth_wr     = (op == 2'd2);
    st_wdata   = data;
    srst_wdata = data[0];
    @(posedge clk);
    #1;
    st_wr = 1'b0; srst_wr = 1'b0; oth_wr = 1'b0;
  endtask

  // counts samples with ready low, starting from the current one
  task automatic count_low(output int n);
    n = 0;
    while (!st_rdata[2] && n < 50) begin
      n++;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk_ctrl(input string tag);
    chk(run_en == (st_rdata[1:0] == 2'd1) && dp_rst == (st_rdata[1:0] == 2'd0),
        tag, {run_en, dp_rst}, st_rdata[1:0]);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(st_rdata == 3'b100, "R1 reset readback", st_rdata, 3'b100);
    chk(!err_o && !run_en && dp_rst, "R1 reset outputs",
        {err_o, run_en, dp_rst}, 3'b001);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [6:0] v;
      v = VEC[i];
      do_wr(v[6:5], v[4:3]);
      chk(st_rdata[1:0] == v[2:1], $sformatf("R2 state vec%0d", i), st_rdata[1:0], v[2:1]);
      chk(st_rdata[2] == v[0], $sformatf("R3 ready vec%0d", i), st_rdata[2], v[0]);
      chk_ctrl($sformatf("R9 ctrl vec%0d", i));
      count_low(n);
      chk(n == (v[0] ? 0 : SETTLE), $sformatf("R3 settle vec%0d", i), n, v[0] ? 0 : SETTLE);
      chk(!err_o, $sformatf("R4 no err vec%0d", i), err_o, 0);
    end

    // R4: write while not ready is ignored and does not restart settle
    do_wr(2'd0, 2'd1);
    do_wr(2'd0, 2'd3);
    chk(st_rdata[1:0] == 2'd1, "R4 busy write ignored", st_rdata[1:0], 1);
    chk(err_o, "R4 err set", err_o, 1);
    count_low(n);
    chk(n == SETTLE - 1, "R4 settle not restarted", n, SETTLE - 1);
    repeat (3) @(posedge clk);
    #1;
    chk(err_o && st_rdata == 3'b101, "R4 err sticky", {err_o, st_rdata}, 4'b1101);

    // R8: software reset overrides a settle window
    do_wr(2'd0, 2'd3);
    do_wr(2'd1, 2'd1);
    chk(st_rdata == 3'b000, "R8 srst while busy", st_rdata, 0);
    chk_ctrl("R9 ctrl after srst");
    count_low(n);
    chk(n == SETTLE, "R8 srst settle", n, SETTLE);

    // R4: err clears only on rst_n
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!err_o && st_rdata == 3'b100, "R1 after rst_n", {err_o, st_rdata}, 4'b0100);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule